// File: doc/BRIEF.md
# Supply supervisor with stretched reset and watchdog

This block watches a digital "supply good" flag produced by an external comparator. It produces a processor reset from that flag and from a watchdog. The reset is given both as an active-high and as an active-low output. When the flag drops, an undervoltage alert and the reset assert at once. When the flag returns, the alert clears at once, but the reset is held for a programmed number of timebase ticks so that the supply and the processor can settle. All timing is counted in ticks of a one-cycle `tick` input. The surrounding logic chooses whether that input comes from an internal divider or an external timebase.

Once the reset releases, a watchdog counts ticks. Software keeps it quiet by producing falling edges on the strobe input. The strobe is resynchronised through two flops before its edge is detected. If the count reaches its limit, the watchdog asserts a latched, active-low status output and starts a new reset pulse of the same programmed width. After that pulse the watchdog re-arms.

The controller is a three-state machine:
- UNDER: supply bad.
- HOLD: reset stretching.
- RUN: reset released, watchdog armed.

Its transitions are:
- supply-loss: any state to UNDER.
- recovery: UNDER to HOLD.
- release: HOLD to RUN, on the final reset tick.
- expiry: RUN to HOLD, on the final watchdog tick with no strobe edge.
- restart: RUN to RUN, when a strobe edge clears the count.

One counter serves both HOLD and RUN.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `supply_ok` is 0, `uv_alert` is 1, `rst_hi` is 1 and `wd_stat_n` is 0, combinationally in the same cycle.
- R2: When `supply_ok` returns to 1, `uv_alert` drops at once. `rst_hi` stays 1 until the clock edge that samples the RST_TICKS-th tick counted since recovery.
- R3: The watchdog counts ticks only while the reset is released. Ticks seen during UNDER or HOLD do not advance it.
- R4: With no strobe falling edge, the edge that samples the WD_TICKS-th watchdog tick is an expiry. `rst_hi` becomes 1 for a fresh RST_TICKS-tick pulse, and `wd_stat_n` becomes 0. It stays 0 after the reset releases.
- R5: A falling edge on `strobe_in` is acted on at the third clock edge after the pin falls, because of two synchroniser flops and one edge flop. It clears the watchdog count to zero and sets `wd_stat_n` to 1.
- R6: When a strobe edge and the final watchdog tick are acted on at the same clock edge, the strobe wins. There is no expiry, and a full WD_TICKS ticks are needed afterwards.
- R7: While `wd_disable` is 1, the watchdog count is held at zero, `wd_stat_n` is 1 whenever the supply is good, and no expiry occurs however many ticks arrive.
- R8: A supply loss during the reset stretch restarts the full RST_TICKS count after the next recovery.
- R9: `rst_lo_n` is always the complement of `rst_hi`.
- R10: While `arst_n` is 0, the machine is held in UNDER with the count cleared. With `supply_ok` at 0, this shows as `uv_alert`=1, `rst_hi`=1 and `wd_stat_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timebase pulse that paces both the reset width and the watchdog |
| supply_ok | input | 1 | 1 when the external comparator reports the supply in tolerance |
| strobe_in | input | 1 | Asynchronous watchdog strobe; a falling edge restarts the watchdog |
| wd_disable | input | 1 | 1 disables the watchdog (strobe pin not connected) |
| uv_alert | output | 1 | Undervoltage alert, active high, not stretched |
| rst_hi | output | 1 | Stretched reset, active high |
| rst_lo_n | output | 1 | Stretched reset, active low |
| wd_stat_n | output | 1 | Latched watchdog status, active low |

## Verification
A restart by a strobe edge and an expiry on the final tick can both fall on one clock edge. The bench provokes this by running the count to WD_TICKS-1. It then lowers the strobe two cycles ahead, so that the synchronised edge and the last tick land on the same edge. The result is judged by a reset that stays released and a status that stays high. A further WD_TICKS ticks are then needed before an expiry, which shows the count restarted from zero.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_UNDER = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic strobe_async,
    output logic strobe_fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) sync_q[0] <= 1'b1;
                    else         sync_q[0] <= strobe_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) sync_q[g] <= 1'b1;
                    else         sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) last_q <= 1'b1;
        else         last_q <= sync_q[SYNC_STAGES-1];
    end

    assign strobe_fall = last_q & ~sync_q[SYNC_STAGES-1];

    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!arst_n)
        strobe_fall |=> !strobe_fall);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)  count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (inc && !clr) |-> (count != {CNT_W{1'b1}}));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int RST_TICKS   = 50,
    parameter int WD_TICKS    = 150,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic strobe_in,
    input  logic wd_disable,
    output logic uv_alert,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic wd_stat_n
);
    localparam int MAX_TICKS = (RST_TICKS > WD_TICKS) ? RST_TICKS : WD_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_TICKS - 1);
    localparam logic [CNT_W-1:0] WD_LAST  = CNT_W'(WD_TICKS - 1);

    sup_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_inc, expire, stb_fall, wd_fired_q;

    strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk          (clk),
        .arst_n       (arst_n),
        .strobe_async (strobe_in),
        .strobe_fall  (stb_fall)
    );

    tick_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk    (clk),
        .arst_n (arst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .count  (cnt)
    );

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_UNDER;
        else         state_q <= state_d;
    end

    // next state and counter control
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        expire  = 1'b0;
        unique case (state_q)
            ST_UNDER: begin
                cnt_clr = 1'b1;
                if (supply_ok) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!supply_ok) begin
                    state_d = ST_UNDER;
                    cnt_clr = 1'b1;
                end else if (tick && cnt == RST_LAST) begin
                    state_d = ST_RUN;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = tick;
                end
            end
            ST_RUN: begin
                if (!supply_ok) begin
                    state_d = ST_UNDER;
                    cnt_clr = 1'b1;
                end else if (wd_disable || stb_fall) begin
                    cnt_clr = 1'b1;
                end else if (tick && cnt == WD_LAST) begin
                    state_d = ST_HOLD;
                    cnt_clr = 1'b1;
                    expire  = 1'b1;
                end else begin
                    cnt_inc = tick;
                end
            end
            default: begin
                state_d = ST_UNDER;
                cnt_clr = 1'b1;
            end
        endcase
    end

    // watchdog status latch
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                      wd_fired_q <= 1'b0;
        else if (expire)                  wd_fired_q <= 1'b1;
        else if (stb_fall || wd_disable)  wd_fired_q <= 1'b0;
    end

    // outputs
    always_comb begin
        uv_alert  = ~supply_ok;
        rst_hi    = ~supply_ok | (state_q != ST_RUN);
        rst_lo_n  = ~rst_hi;
        wd_stat_n = ~(wd_fired_q | ~supply_ok);
    end

    assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_hi) |-> (supply_ok && $past(supply_ok)));

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(rst_hi) |-> ($past(tick) && $past(state_q) == ST_HOLD));

    assert_expiry_sets_status_R4: assert property (@(posedge clk) disable iff (!arst_n)
        ($rose(rst_hi) && supply_ok && $past(supply_ok)) |-> !wd_stat_n);

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(wd_disable) && supply_ok) |-> wd_stat_n);

    assert_loss_forces_under_R8: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> (state_q == ST_UNDER));

    assert_complement_R9: assert property (@(posedge clk) disable iff (!arst_n)
        rst_lo_n != rst_hi);
endmodule

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic tick = 1'b0, supply_ok = 1'b0, strobe_in = 1'b1, wd_disable = 1'b0;
    logic uv_alert, rst_hi, rst_lo_n, wd_stat_n;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sup_reset_ctrl #(.RST_TICKS(3), .WD_TICKS(4)) i_sup_reset_ctrl (
        .clk(clk), .arst_n(arst_n), .tick(tick), .supply_ok(supply_ok),
        .strobe_in(strobe_in), .wd_disable(wd_disable), .uv_alert(uv_alert),
        .rst_hi(rst_hi), .rst_lo_n(rst_lo_n), .wd_stat_n(wd_stat_n)
    );

    // {supply, strobe, disable, tick, exp_uv, exp_rst, exp_wds_n}
    localparam logic [6:0] VEC [0:24] = '{
        7'b1100_011, 7'b1101_011, 7'b1101_011, 7'b1101_001, // R2 release after 3 ticks
        7'b1101_001, 7'b1101_001, 7'b1101_001, 7'b1101_010, // R3/R4 expiry on 4th tick
        7'b1101_010, 7'b1101_010, 7'b1101_000,              // R4 pulse, status stays low
        7'b1000_000, 7'b1000_000, 7'b1000_001,              // R5 sync delay then clear
        7'b1011_001, 7'b1011_001, 7'b1011_001, 7'b1011_001, 7'b1011_001, // R7
        7'b0010_110, 7'b0001_110,                           // R1 undervoltage
        7'b1000_011, 7'b1001_011, 7'b1001_011, 7'b1001_001  // R2 second recovery
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic st, input logic d, input logic t);
        @(negedge clk);
        supply_ok = s; strobe_in = st; wd_disable = d; tick = t;
        @(posedge clk);
        #5;
        chk("R9 complement", rst_lo_n, ~rst_hi);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk("R10 reset uv", uv_alert, 1'b1);
        chk("R10 reset rst", rst_hi, 1'b1);
        chk("R10 reset rst_n", rst_lo_n, 1'b0);
        chk("R10 reset wds", wd_stat_n, 1'b0);
        @(negedge clk);
        arst_n = 1'b1;

        for (int i = 0; i < 25; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            chk($sformatf("R1/R2 uv vec%0d", i), uv_alert, VEC[i][2]);
            chk($sformatf("R2/R4 rst vec%0d", i), rst_hi, VEC[i][1]);
            chk($sformatf("R4/R5/R7 wds vec%0d", i), wd_stat_n, VEC[i][0]);
        end

        // R6: strobe edge and final watchdog tick on the same edge
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1);
        chk("R3 no early expiry", rst_hi, 1'b0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        chk("R6 strobe wins rst", rst_hi, 1'b0);
        chk("R6 strobe wins wds", wd_stat_n, 1'b1);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1);
        chk("R6 count restarted", rst_hi, 1'b0);
        step(1, 0, 0, 1);
        chk("R6 expiry after full period", rst_hi, 1'b1);
        chk("R4 status latched", wd_stat_n, 1'b0);

        // R8: supply loss mid-stretch restarts the width
        step(1, 0, 0, 1);
        step(0, 0, 0, 0);
        chk("R8 loss uv", uv_alert, 1'b1);
        chk("R8 loss rst", rst_hi, 1'b1);
        step(1, 0, 0, 0);
        chk("R2 uv clears at once", uv_alert, 1'b0);
        step(1, 0, 0, 1);
        step(1, 0, 0, 1);
        chk("R8 still held after 2 ticks", rst_hi, 1'b1);
        step(1, 0, 0, 1);
        chk("R8 release after full width", rst_hi, 1'b0);
        chk("R4 status kept after release", wd_stat_n, 1'b0);

        finish_run();
    end
endmodule